// File: doc/BRIEF.md
# Memory ECC Error Logger

This block sits beside a DRAM controller's data path and records the ECC error events it reports. Two strobes arrive from the checker, one for correctable single-bit errors and one for uncorrectable multi-bit errors. Each strobe carries the physical address that failed and the index of the DRAM row (one of eight) that was hit. The logger keeps three things. The first is an error address register that holds the 4 KB page of the captured error, along with flags naming its class. The second is a status register with a sticky "occurred" flag and a first-error row number for each class. The third is a command register that chooses which classes raise a system-error signal.

Software reads and writes these registers through a small select/write port with combinational readback. It clears flags by writing ones to them. The address register freezes while any of its flags is set, so the page it shows always belongs to the error that its flags describe. A 2-bit integrity-mode input turns logging on or off. When it reads "off", no event reaches any register and no system-error pulse is produced.

Top module: `ecc_err_log`

## Requirements
- R1: After a synchronous reset, the address, status and command registers read zero and `sys_err` is low.
- R2: Register select 0 reads the address register. It holds failing address bits [31:12] in bits [31:12], bits [11:2] read zero, bit 0 is the single-bit flag and bit 1 is the multi-bit flag. On capture, exactly one flag is set, naming the class whose address was taken.
- R3: While either address-register flag is set, further errors leave the whole address register unchanged.
- R4: Register select 1 reads the status register. Bit 0 is a sticky single-bit flag and bits [3:1] hold the row of the first single-bit error. Bit 4 is a sticky multi-bit flag and bits [7:5] hold the row of the first multi-bit error. A row field updates only when its flag goes from clear to set.
- R5: Writing 1 to a flag position (address bits 0/1, status bits 0/4) clears that flag. Writing 0 leaves it untouched, and row fields and the address page are kept.
- R6: With integrity mode 00, no error is logged in any register and `sys_err` stays low. Modes 01, 10 and 11 all log.
- R7: Register select 2 reads the command register in bits [1:0]: bit 0 enables single-bit signalling and bit 1 enables multi-bit signalling. Select 3 reads zero. `sys_err` is high for exactly the one cycle after each logged error whose class is enabled.
- R8: When both strobes fire in the same cycle with the address unlocked, the multi-bit address is captured with only the multi-bit address flag set. Both status flags and both row fields are still recorded.
- R9: When an error and a clearing write to the same flag occur in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| integ_mode | input | 2 | Integrity mode: 00 off, 01 detect, 10 correct, 11 correct with scrub |
| sb_hit | input | 1 | Single-bit error strobe |
| sb_addr | input | 32 | Failing address of the single-bit error |
| sb_row | input | 3 | DRAM row of the single-bit error |
| mb_hit | input | 1 | Multi-bit error strobe |
| mb_addr | input | 32 | Failing address of the multi-bit error |
| mb_row | input | 3 | DRAM row of the multi-bit error |
| reg_sel | input | 2 | Register select: 0 address, 1 status, 2 command, 3 none |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| sys_err | output | 1 | One-cycle system-error pulse |

## Verification
The logger is tried with events of a single class in each of the three logging modes, with both classes at once, and with the off mode. This shows whether the class flag, page and row land in the right fields and whether mode 00 blocks everything. The command enables are varied across these events, so each class's contribution to the pulse is checked separately. The directed tests follow on from the last table entry. They send a second error while flags are still set, which separates the address lock from the per-class stickiness of the status rows. They write zeros and ones to the flag positions to separate clearing from no-ops. They also set and clear a flag in the same cycle.

// File: rtl/ecclog_pkg.sv
package ecclog_pkg;

    parameter int ADDR_W   = 32;
    parameter int PAGE_LSB = 12;
    parameter int ROW_W    = 3;
    parameter int N_CLASS  = 2;

    localparam int CLS_SB = 0;
    localparam int CLS_MB = 1;

    localparam int AFLAG_SB = 0;
    localparam int AFLAG_MB = 1;
    localparam int SFLAG_SB = 0;
    localparam int SFLAG_MB = 1 + ROW_W;
    localparam int STS_W    = 2 * (1 + ROW_W);

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_DETECT  = 2'b01,
        MODE_CORRECT = 2'b10,
        MODE_SCRUB   = 2'b11
    } integ_mode_e;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CMD  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] addr;
        logic [ROW_W-1:0]  row;
    } err_evt_t;

    function automatic logic logging_on(input logic [1:0] mode);
        return integ_mode_e'(mode) != MODE_OFF;
    endfunction

endpackage

// File: rtl/ecclog_addr_cap.sv
module ecclog_addr_cap
    import ecclog_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int PLB = PAGE_LSB
) (
    input  logic           clk,
    input  logic           rst,
    input  err_evt_t       sb_evt,
    input  err_evt_t       mb_evt,
    input  logic           clr_sb,
    input  logic           clr_mb,
    output logic [AW-1:PLB] page_q,
    output logic           sb_flag,
    output logic           mb_flag
);

    logic locked;
    logic take;
    logic [AW-1:PLB] page_d;

    assign locked = sb_flag | mb_flag;
    assign take   = !locked && (sb_evt.hit || mb_evt.hit);
    assign page_d = mb_evt.hit ? mb_evt.addr[AW-1:PLB] : sb_evt.addr[AW-1:PLB];

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q  <= '0;
            sb_flag <= 1'b0;
            mb_flag <= 1'b0;
        end else if (take) begin
            page_q  <= page_d;
            mb_flag <= mb_evt.hit;
            sb_flag <= !mb_evt.hit;
        end else begin
            if (clr_sb) sb_flag <= 1'b0;
            if (clr_mb) mb_flag <= 1'b0;
        end
    end

    AST_ADDR_LOCK: assert property (@(posedge clk) disable iff (rst)
        (sb_flag || mb_flag) |=> $stable(page_q)) else $error("lock"); // R3

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!sb_flag && !mb_flag && (sb_evt.hit || mb_evt.hit)) |=> $onehot0({sb_flag, mb_flag}) && (sb_flag || mb_flag)) else $error("flag"); // R2

    AST_MB_WINS: assert property (@(posedge clk) disable iff (rst)
        (!sb_flag && !mb_flag && sb_evt.hit && mb_evt.hit) |=> (mb_flag && !sb_flag)) else $error("mb wins"); // R8

endmodule

// File: rtl/ecclog_first_slot.sv
module ecclog_first_slot
    import ecclog_pkg::*;
#(
    parameter int RW = ROW_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  logic [RW-1:0] row,
    input  logic          clr,
    output logic          flag,
    output logic [RW-1:0] row_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            row_q <= '0;
        end else if (hit) begin
            flag <= 1'b1;
            if (!flag) row_q <= row;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    AST_ROW_KEPT: assert property (@(posedge clk) disable iff (rst)
        flag |=> $stable(row_q)) else $error("row"); // R4

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (hit && clr) |=> flag) else $error("set wins"); // R9

endmodule

// File: rtl/ecclog_signal.sv
module ecclog_signal
    import ecclog_pkg::*;
#(
    parameter int NC = N_CLASS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_wr,
    input  logic [NC-1:0] cmd_wdata,
    input  logic [NC-1:0] logged,
    output logic [NC-1:0] enable_q,
    output logic          sys_err
);

    logic fire;
    assign fire = |(logged & enable_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            sys_err  <= 1'b0;
        end else begin
            if (cmd_wr) enable_q <= cmd_wdata;
            sys_err <= fire;
        end
    end

    AST_SERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        sys_err |-> $past(|(logged & enable_q))) else $error("serr"); // R7

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecclog_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int PLB = PAGE_LSB,
    parameter int RW  = ROW_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    integ_mode,
    input  logic          sb_hit,
    input  logic [AW-1:0] sb_addr,
    input  logic [RW-1:0] sb_row,
    input  logic          mb_hit,
    input  logic [AW-1:0] mb_addr,
    input  logic [RW-1:0] mb_row,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic          sys_err
);

    localparam int SW  = 2 * (1 + RW);
    localparam int SMB = 1 + RW;

    logic     log_en;
    err_evt_t evt [N_CLASS];
    logic [N_CLASS-1:0] logged;

    assign log_en = logging_on(integ_mode);
    assign evt[CLS_SB] = '{hit: sb_hit && log_en, addr: sb_addr, row: sb_row};
    assign evt[CLS_MB] = '{hit: mb_hit && log_en, addr: mb_addr, row: mb_row};

    logic wr_addr, wr_stat, wr_cmd;
    assign wr_addr = reg_wr && (reg_sel_e'(reg_sel) == SEL_ADDR);
    assign wr_stat = reg_wr && (reg_sel_e'(reg_sel) == SEL_STAT);
    assign wr_cmd  = reg_wr && (reg_sel_e'(reg_sel) == SEL_CMD);

    logic [AW-1:PLB] page_q;
    logic            a_sb, a_mb;

    ecclog_addr_cap #(.AW(AW), .PLB(PLB)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .sb_evt  (evt[CLS_SB]),
        .mb_evt  (evt[CLS_MB]),
        .clr_sb  (wr_addr && reg_wdata[AFLAG_SB]),
        .clr_mb  (wr_addr && reg_wdata[AFLAG_MB]),
        .page_q  (page_q),
        .sb_flag (a_sb),
        .mb_flag (a_mb)
    );

    logic [N_CLASS-1:0] s_flag;
    logic [RW-1:0]      s_row [N_CLASS];

    for (genvar k = 0; k < N_CLASS; k++) begin : g_slot
        localparam int FBIT = (k == CLS_SB) ? 0 : SMB;
        assign logged[k] = evt[k].hit;
        ecclog_first_slot #(.RW(RW)) u_slot (
            .clk   (clk),
            .rst   (rst),
            .hit   (evt[k].hit),
            .row   (evt[k].row),
            .clr   (wr_stat && reg_wdata[FBIT]),
            .flag  (s_flag[k]),
            .row_q (s_row[k])
        );
    end

    logic [N_CLASS-1:0] enable_q;

    ecclog_signal #(.NC(N_CLASS)) u_sig (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (wr_cmd),
        .cmd_wdata (reg_wdata[N_CLASS-1:0]),
        .logged    (logged),
        .enable_q  (enable_q),
        .sys_err   (sys_err)
    );

    logic [SW-1:0] status;
    assign status = {s_row[CLS_MB], s_flag[CLS_MB], s_row[CLS_SB], s_flag[CLS_SB]};

    always_comb begin
        unique case (reg_sel_e'(reg_sel))
            SEL_ADDR: reg_rdata = {page_q, {(PLB-2){1'b0}}, a_mb, a_sb};
            SEL_STAT: reg_rdata = {{(AW-SW){1'b0}}, status};
            SEL_CMD:  reg_rdata = {{(AW-N_CLASS){1'b0}}, enable_q};
            default:  reg_rdata = '0;
        endcase
    end

    AST_MODE_OFF: assert property (@(posedge clk) disable iff (rst)
        (integ_mode == 2'b00 && !reg_wr) |=> ($stable(status) && $stable(page_q) && !sys_err)) else $error("off"); // R6

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (s_flag[CLS_SB] && !wr_stat) |=> s_flag[CLS_SB]) else $error("sticky"); // R4

endmodule

// File: tb/ecc_err_log_bench.sv
module ecc_err_log_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  integ_mode = 2'b00;
    logic        sb_hit = 1'b0, mb_hit = 1'b0;
    logic [31:0] sb_addr = '0, mb_addr = '0;
    logic [2:0]  sb_row = '0, mb_row = '0;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sys_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ecc_err_log u_ecc_err_log (
        .clk(clk), .rst(rst), .integ_mode(integ_mode),
        .sb_hit(sb_hit), .sb_addr(sb_addr), .sb_row(sb_row),
        .mb_hit(mb_hit), .mb_addr(mb_addr), .mb_row(mb_row),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sys_err(sys_err)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        sb;
        logic [31:0] sa;
        logic [2:0]  sr;
        logic        mb;
        logic [31:0] ma;
        logic [2:0]  mr;
        logic [1:0]  cmd;
        logic [31:0] e_addr;
        logic [7:0]  e_sts;
        logic        e_serr;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'b10, 1'b1, 32'h1234_5678, 3'd3, 1'b0, 32'h0,         3'd0, 2'b01, 32'h1234_5001, 8'h07, 1'b1},
        '{2'b10, 1'b0, 32'h0,         3'd0, 1'b1, 32'h8000_0FFF, 3'd5, 2'b01, 32'h8000_0002, 8'hB0, 1'b0},
        '{2'b11, 1'b1, 32'h1111_1000, 3'd1, 1'b1, 32'h2222_2ABC, 3'd7, 2'b11, 32'h2222_2002, 8'hF3, 1'b1},
        '{2'b00, 1'b1, 32'h3333_3000, 3'd2, 1'b1, 32'h4444_4000, 3'd4, 2'b11, 32'h0000_0000, 8'h00, 1'b0},
        '{2'b01, 1'b1, 32'hFFFF_FFFF, 3'd0, 1'b0, 32'h0,         3'd0, 2'b10, 32'hFFFF_F001, 8'h01, 1'b0},
        '{2'b01, 1'b0, 32'h0,         3'd0, 1'b1, 32'h0000_0000, 3'd2, 2'b10, 32'h0000_0002, 8'h50, 1'b1},
        '{2'b11, 1'b0, 32'h0,         3'd0, 1'b0, 32'h0,         3'd0, 2'b11, 32'h0000_0000, 8'h00, 1'b0},
        '{2'b10, 1'b1, 32'hABCD_E123, 3'd6, 1'b0, 32'h0,         3'd0, 2'b00, 32'hABCD_E001, 8'h0D, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp,
                         input logic [31:0] mask);
        n_chk++;
        if ((act & mask) !== (exp & mask)) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (mask %h)", req, what, act, exp, mask);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic fire(input logic [1:0] mode, input logic s, input logic [31:0] sa,
                        input logic [2:0] sr, input logic m, input logic [31:0] ma,
                        input logic [2:0] mr);
        integ_mode = mode;
        sb_hit = s; sb_addr = sa; sb_row = sr;
        mb_hit = m; mb_addr = ma; mb_row = mr;
        @(negedge clk);
        sb_hit = 1'b0; mb_hit = 1'b0;
        #1;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] am, sm;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        rd(2'd0, v); check("R1", "addr reset", v, 32'h0, '1);
        rd(2'd1, v); check("R1", "status reset", v, 32'h0, '1);
        rd(2'd2, v); check("R1", "cmd reset", v, 32'h0, '1);
        check("R1", "sys_err reset", {31'b0, sys_err}, 32'h0, '1);
        @(negedge clk);

        // table walk: R2 R4 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            wr(2'd2, {30'b0, VECS[i].cmd});
            wr(2'd0, 32'h3);
            wr(2'd1, 32'h11);
            fire(VECS[i].mode, VECS[i].sb, VECS[i].sa, VECS[i].sr,
                 VECS[i].mb, VECS[i].ma, VECS[i].mr);
            check("R7", "sys_err pulse", {31'b0, sys_err}, {31'b0, VECS[i].e_serr}, '1);
            am = (VECS[i].e_addr[1:0] != 2'b00) ? 32'hFFFF_FFFF : 32'h0000_0FFF;
            sm = (VECS[i].e_sts[0] ? 32'h0F : 32'h01) | (VECS[i].e_sts[4] ? 32'hF0 : 32'h10);
            rd(2'd0, v); check("R2 R8 R6", "addr reg", v, VECS[i].e_addr, am);
            rd(2'd1, v); check("R4 R8 R6", "status reg", v, {24'b0, VECS[i].e_sts}, sm);
            @(negedge clk); #1;
            check("R7", "sys_err one cycle", {31'b0, sys_err}, 32'h0, '1);
        end

        // R3: locked address ignores a later multi-bit error
        wr(2'd2, 32'h3);
        fire(2'b10, 1'b0, 32'h0, 3'd0, 1'b1, 32'h5555_5000, 3'd4);
        check("R7", "mb enabled pulse", {31'b0, sys_err}, 32'h1, '1);
        rd(2'd0, v); check("R3", "addr locked", v, 32'hABCD_E001, '1);
        rd(2'd1, v); check("R4", "mb first row", v, 32'h9D, '1);
        @(negedge clk); #1;

        // R4: second single-bit error keeps first row
        fire(2'b10, 1'b1, 32'h7777_7000, 3'd2, 1'b0, 32'h0, 3'd0);
        rd(2'd1, v); check("R4", "sb row kept", v, 32'h9D, '1);
        rd(2'd0, v); check("R3", "addr still locked", v, 32'hABCD_E001, '1);
        @(negedge clk);

        // R5: write-one-to-clear
        wr(2'd0, 32'h0);
        rd(2'd0, v); check("R5", "write 0 no effect", v, 32'hABCD_E001, '1);
        wr(2'd0, 32'h2);
        rd(2'd0, v); check("R5", "clear unset flag", v, 32'hABCD_E001, '1);
        wr(2'd0, 32'h1);
        rd(2'd0, v); check("R5", "clear sb addr flag", v, 32'hABCD_E000, '1);
        wr(2'd1, 32'h0);
        rd(2'd1, v); check("R5", "status write 0", v, 32'h9D, '1);
        wr(2'd1, 32'h10);
        rd(2'd1, v); check("R5", "clear mb status flag", v, 32'h8D, '1);

        // R9: set and clear in the same cycle
        reg_sel = 2'd1; reg_wdata = 32'h1; reg_wr = 1'b1;
        fire(2'b01, 1'b1, 32'h0000_3FFF, 3'd1, 1'b0, 32'h0, 3'd0);
        reg_wr = 1'b0; reg_wdata = '0;
        rd(2'd1, v); check("R9", "set beats clear", v, 32'h8D, '1);
        rd(2'd0, v); check("R2", "unlocked capture", v, 32'h0000_3001, '1);

        // R7: command readback and empty select
        rd(2'd2, v); check("R7", "cmd readback", v, 32'h3, '1);
        rd(2'd3, v); check("R7", "select 3 zero", v, 32'h0, '1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule